// File: doc/BRIEF.md
# Bit-Serial Integer ALU

This block is the arithmetic and logic stage of a one-bit-wide 32-bit integer core. Each operation is one pass: the caller feeds one bit of every operand per valid beat, least significant bit first, for `XLEN` valid beats. Operand A arrives on the rs1 stream. Operand B arrives on either the rs2 stream or the immediate stream. Each valid beat produces one result bit on a registered output one cycle later. The result can be the serial sum or difference, a bitwise boolean, or a set-less-than word.

Subtraction reuses the adder. The B bit is inverted and the carry starts the pass at 1. The same difference drives two compare results. Equality is true when every difference bit is zero. Less-than is the sign of a 33-bit difference, and its extra top bit is formed on the final beat together with bit 31, so a pass never needs a 33rd beat. At the end of each pass a compare flag is registered for branch decisions. The less-than result is also kept, so that a following set-less-than pass can emit it as bit 0.

The block counts valid beats itself, and `i_valid` may drop between beats. Control inputs must stay constant for the whole pass.

Top module: `serial_alu`

## Requirements
- R1: With result select 0 (sum) and subtract off, the `o_rd` bits of a pass, collected LSB first, equal the low 32 bits of A + B. Each bit appears one clock after the beat that carried it.
- R2: When `i_b_imm` is 1, operand B is taken from `i_imm` and `i_rs2` has no effect. When `i_b_imm` is 0, operand B is taken from `i_rs2`.
- R3: With `i_sub` set and result select 0, the output word equals A + ~B + 1, which is A − B modulo 2^32.
- R4: With `i_sub` and `i_cmp_signed` set and `i_cmp_eq` clear, the compare result at the end of a pass is 1 exactly when A < B as two's-complement numbers.
- R5: With `i_sub` set and `i_cmp_signed` clear, the less-than result is 1 exactly when A < B as unsigned numbers. In this case the 33rd bit of both operands is 0.
- R6: With `i_sub` and `i_cmp_eq` set, the compare result is 1 only if every bit of A − B is zero. A single differing bit at any position, including bit 0 or bit 31, gives 0.
- R7: `o_cmp_valid` pulses high for one cycle, in the cycle after the last beat of a pass. `o_cmp` takes its new value at that same time and holds it until the next pass ends.
- R8: With result select 1 (set-less-than), bit 0 of the output word equals the less-than result of the most recent completed pass, and bits 1 to 31 are 0.
- R9: With result select 2 (boolean), each output bit is A op B, where `i_bool_sel` 0 = XOR, 1 = OR, 2 = AND, and 3 gives 0. Result select 3 also gives 0.
- R10: While `rst` is high and after it falls, `o_rd`, `o_rd_valid`, `o_cmp` and `o_cmp_valid` are 0 until the first beat has been processed.
- R11: `o_rd_valid` is `i_valid` delayed by one cycle, and `o_rd` is 0 when `o_rd_valid` is 0. Idle cycles inside a pass leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Beat qualifier: operand bits on this cycle are consumed |
| i_rs1 | input | 1 | Operand A bit |
| i_rs2 | input | 1 | Register operand B bit |
| i_imm | input | 1 | Immediate operand B bit |
| i_b_imm | input | 1 | 1 selects the immediate stream as B |
| i_sub | input | 1 | Subtract mode (invert B, carry preset to 1) |
| i_cmp_signed | input | 1 | Signed compare: sign-extend both operands |
| i_cmp_eq | input | 1 | Compare flag reports equality (1) or less-than (0) |
| i_res_sel | input | 2 | Result stream: 0 sum, 1 set-less-than, 2 boolean, 3 zero |
| i_bool_sel | input | 2 | Boolean op: 0 XOR, 1 OR, 2 AND, 3 zero |
| o_rd | output | 1 | Registered result bit |
| o_rd_valid | output | 1 | Result bit qualifier |
| o_cmp | output | 1 | Compare flag of the last completed pass |
| o_cmp_valid | output | 1 | One-cycle pulse when `o_cmp` is updated |

## Verification
The bench targets the carry and sign corners. These include a carry that ripples through all 32 bits, operands that differ only in bit 0 or only in bit 31, and the signed/unsigned split on values such as 0x80000000 against 0x7FFFFFFF and 0xFFFFFFFF against 1. A design that took the 33rd bit from the wrong operand's MSB, or from a stale carry, would flip exactly those less-than answers. An equality flag that was not reset at the first beat would carry a mismatch over from the previous pass. A beat counter that advanced on idle cycles would misplace the carry preset and the final compare when `i_valid` gaps inside a pass. In a set-less-than pass, a stale or misplaced bit 0 would show up as a wrong word.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;
  typedef enum logic [1:0] {
    RES_SUM  = 2'd0,
    RES_SLT  = 2'd1,
    RES_BOOL = 2'd2,
    RES_NONE = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    BOOL_XOR  = 2'd0,
    BOOL_OR   = 2'd1,
    BOOL_AND  = 2'd2,
    BOOL_ZERO = 2'd3
  } bool_sel_e;
endpackage

// File: rtl/sa_beat_ctr.sv
module sa_beat_ctr #(
  parameter int XLEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic i_valid,
  output logic o_first,
  output logic o_last
);
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(XLEN - 1);

  logic [CW-1:0] idx_q;

  assign o_first = (idx_q == '0);
  assign o_last  = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (i_valid) begin
      idx_q <= o_last ? '0 : idx_q + CW'(1);
    end
  end
endmodule

// File: rtl/sa_addsub.sv
module sa_addsub (
  input  logic clk,
  input  logic rst,
  input  logic i_valid,
  input  logic i_first,
  input  logic i_a,
  input  logic i_b,
  input  logic i_sub,
  output logic o_sum,
  output logic o_cout
);
  logic carry_q;
  logic b_eff;
  logic cin;

  assign b_eff  = i_b ^ i_sub;
  assign cin    = i_first ? i_sub : carry_q;
  assign o_sum  = i_a ^ b_eff ^ cin;
  assign o_cout = (i_a & b_eff) | (i_a & cin) | (b_eff & cin);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (i_valid) begin
      carry_q <= o_cout;
    end
  end
endmodule

// File: rtl/sa_cmp.sv
module sa_cmp (
  input  logic clk,
  input  logic rst,
  input  logic i_valid,
  input  logic i_first,
  input  logic i_last,
  input  logic i_a,
  input  logic i_b,
  input  logic i_sub,
  input  logic i_sig,
  input  logic i_sum,
  input  logic i_cout,
  input  logic i_sel_eq,
  output logic o_cmp,
  output logic o_cmp_valid,
  output logic o_lt_held
);
  logic eq_q;
  logic eq_now;
  logic a_ext;
  logic b_ext;
  logic lt_now;
  logic cmp_q;
  logic cmp_v_q;
  logic lt_q;

  assign eq_now = (i_first | eq_q) & ~i_sum;
  assign a_ext  = i_sig & i_a;
  assign b_ext  = i_sig & i_b;
  assign lt_now = a_ext ^ (b_ext ^ i_sub) ^ i_cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q    <= 1'b0;
      cmp_q   <= 1'b0;
      cmp_v_q <= 1'b0;
      lt_q    <= 1'b0;
    end else begin
      cmp_v_q <= i_valid & i_last;
      if (i_valid) begin
        eq_q <= eq_now;
        if (i_last) begin
          lt_q  <= lt_now;
          cmp_q <= i_sel_eq ? eq_now : lt_now;
        end
      end
    end
  end

  assign o_cmp       = cmp_q;
  assign o_cmp_valid = cmp_v_q;
  assign o_lt_held   = lt_q;
endmodule

// File: rtl/sa_logic.sv
module sa_logic
  import serial_alu_pkg::*;
(
  input  logic       i_a,
  input  logic       i_b,
  input  logic [1:0] i_sel,
  output logic       o_res
);
  always_comb begin
    case (bool_sel_e'(i_sel))
      BOOL_XOR: o_res = i_a ^ i_b;
      BOOL_OR:  o_res = i_a | i_b;
      BOOL_AND: o_res = i_a & i_b;
      default:  o_res = 1'b0;
    endcase
  end
endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       i_valid,
  input  logic       i_rs1,
  input  logic       i_rs2,
  input  logic       i_imm,
  input  logic       i_b_imm,
  input  logic       i_sub,
  input  logic       i_cmp_signed,
  input  logic       i_cmp_eq,
  input  logic [1:0] i_res_sel,
  input  logic [1:0] i_bool_sel,
  output logic       o_rd,
  output logic       o_rd_valid,
  output logic       o_cmp,
  output logic       o_cmp_valid
);
  logic beat_first;
  logic beat_last;
  logic op_b;
  logic sum_bit;
  logic sum_cout;
  logic bool_bit;
  logic lt_held;
  logic res_bit;
  logic rd_q;
  logic rd_v_q;

  assign op_b = i_b_imm ? i_imm : i_rs2;

  sa_beat_ctr #(.XLEN(XLEN)) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .i_valid (i_valid),
    .o_first (beat_first),
    .o_last  (beat_last)
  );

  sa_addsub addsub_i (
    .clk     (clk),
    .rst     (rst),
    .i_valid (i_valid),
    .i_first (beat_first),
    .i_a     (i_rs1),
    .i_b     (op_b),
    .i_sub   (i_sub),
    .o_sum   (sum_bit),
    .o_cout  (sum_cout)
  );

  sa_cmp cmp_i (
    .clk         (clk),
    .rst         (rst),
    .i_valid     (i_valid),
    .i_first     (beat_first),
    .i_last      (beat_last),
    .i_a         (i_rs1),
    .i_b         (op_b),
    .i_sub       (i_sub),
    .i_sig       (i_cmp_signed),
    .i_sum       (sum_bit),
    .i_cout      (sum_cout),
    .i_sel_eq    (i_cmp_eq),
    .o_cmp       (o_cmp),
    .o_cmp_valid (o_cmp_valid),
    .o_lt_held   (lt_held)
  );

  sa_logic logic_i (
    .i_a   (i_rs1),
    .i_b   (op_b),
    .i_sel (i_bool_sel),
    .o_res (bool_bit)
  );

  always_comb begin
    case (res_sel_e'(i_res_sel))
      RES_SUM:  res_bit = sum_bit;
      RES_SLT:  res_bit = beat_first & lt_held;
      RES_BOOL: res_bit = bool_bit;
      default:  res_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= i_valid;
      rd_q   <= i_valid & res_bit;
    end
  end

  assign o_rd       = rd_q;
  assign o_rd_valid = rd_v_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker (
  input logic       clk,
  input logic       rst,
  input logic       i_valid,
  input logic       i_rs1,
  input logic       i_rs2,
  input logic       i_imm,
  input logic       i_b_imm,
  input logic [1:0] i_res_sel,
  input logic [1:0] i_bool_sel,
  input logic       beat_first,
  input logic       o_rd,
  input logic       o_rd_valid,
  input logic       o_cmp,
  input logic       o_cmp_valid
);
  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_rd_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> (!o_rd_valid && !o_rd));

  assert_cmp_after_beat_R7: assert property (@(posedge clk) disable iff (rst)
    o_cmp_valid |-> $past(i_valid));

  assert_cmp_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    o_cmp_valid |=> !o_cmp_valid);

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !o_cmp_valid |-> $stable(o_cmp));

  assert_slt_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_res_sel == 2'd1 && !beat_first) |=> !o_rd);

  assert_and_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_res_sel == 2'd2 && i_bool_sel == 2'd2)
      |=> (o_rd == $past(i_rs1 & (i_b_imm ? i_imm : i_rs2))));
endmodule

bind serial_alu sa_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .i_valid     (i_valid),
  .i_rs1       (i_rs1),
  .i_rs2       (i_rs2),
  .i_imm       (i_imm),
  .i_b_imm     (i_b_imm),
  .i_res_sel   (i_res_sel),
  .i_bool_sel  (i_bool_sel),
  .beat_first  (beat_first),
  .o_rd        (o_rd),
  .o_rd_valid  (o_rd_valid),
  .o_cmp       (o_cmp),
  .o_cmp_valid (o_cmp_valid)
);

// File: tb/serial_alu_tb_top.sv
module serial_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic       clk = 1'b0;
  logic       rst;
  logic       i_valid, i_rs1, i_rs2, i_imm, i_b_imm, i_sub, i_cmp_signed, i_cmp_eq;
  logic [1:0] i_res_sel, i_bool_sel;
  logic       o_rd, o_rd_valid, o_cmp, o_cmp_valid;

  int checks = 0;
  int fails  = 0;

  logic  bit_q[$];
  string bit_tag_q[$];
  logic  cmp_q[$];
  string cmp_tag_q[$];

  logic lt_model = 1'b0;
  logic last_cmp = 1'b0;
  int   bit_pos  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_alu #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_rs1(i_rs1), .i_rs2(i_rs2),
    .i_imm(i_imm), .i_b_imm(i_b_imm), .i_sub(i_sub), .i_cmp_signed(i_cmp_signed),
    .i_cmp_eq(i_cmp_eq), .i_res_sel(i_res_sel), .i_bool_sel(i_bool_sel),
    .o_rd(o_rd), .o_rd_valid(o_rd_valid), .o_cmp(o_cmp), .o_cmp_valid(o_cmp_valid)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expected bits and compare flags as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (o_rd_valid) begin
        if (bit_q.size() == 0) begin
          check("R11 unexpected result bit", 1'b1, 1'b0);
        end else begin
          check($sformatf("%s bit %0d", bit_tag_q[0], bit_pos), o_rd, bit_q[0]);
          void'(bit_q.pop_front());
          void'(bit_tag_q.pop_front());
          bit_pos = (bit_pos == XLEN-1) ? 0 : bit_pos + 1;
        end
      end
      if (o_cmp_valid) begin
        if (cmp_q.size() == 0) begin
          check("R7 unexpected compare pulse", 1'b1, 1'b0);
        end else begin
          check($sformatf("%s cmp", cmp_tag_q[0]), o_cmp, cmp_q[0]);
          last_cmp = cmp_q[0];
          void'(cmp_q.pop_front());
          void'(cmp_tag_q.pop_front());
        end
      end
    end
  end

  // Driver: computes expectations, queues them, then streams the operands
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic use_imm, input logic sub, input logic sig,
                        input logic sel_eq, input logic [1:0] rsel,
                        input logic [1:0] bsel, input int gap_at, input string tag);
    logic [32:0] ax, bx, s33;
    logic [31:0] word;
    ax  = {sig & a[31], a};
    bx  = {sig & b[31], b};
    s33 = ax + (sub ? ~bx : bx) + {32'd0, sub};
    case (rsel)
      2'd0: word = s33[31:0];
      2'd1: word = {31'd0, lt_model};
      2'd2: case (bsel)
              2'd0: word = a ^ b;
              2'd1: word = a | b;
              2'd2: word = a & b;
              default: word = 32'd0;
            endcase
      default: word = 32'd0;
    endcase
    for (int k = 0; k < XLEN; k++) begin
      bit_q.push_back(word[k]);
      bit_tag_q.push_back(tag);
    end
    cmp_q.push_back(sel_eq ? (s33[31:0] == 32'd0) : s33[32]);
    cmp_tag_q.push_back(tag);
    lt_model = s33[32];
    for (int k = 0; k < XLEN; k++) begin
      if (k == gap_at) begin
        @(negedge clk);
        i_valid = 1'b0;
        i_rs1 = ~a[k]; i_rs2 = ~b[k]; i_imm = ~b[k];
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      i_valid = 1'b1;
      i_rs1 = a[k];
      i_b_imm = use_imm;
      i_imm = use_imm ? b[k] : ~b[k];
      i_rs2 = use_imm ? ~b[k] : b[k];
      i_sub = sub; i_cmp_signed = sig; i_cmp_eq = sel_eq;
      i_res_sel = rsel; i_bool_sel = bsel;
    end
    @(negedge clk);
    i_valid = 1'b0;
    i_rs1 = 1'b1; i_rs2 = 1'b1; i_imm = 1'b1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    i_valid = 0; i_rs1 = 0; i_rs2 = 0; i_imm = 0; i_b_imm = 0; i_sub = 0;
    i_cmp_signed = 0; i_cmp_eq = 0; i_res_sel = 0; i_bool_sel = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 o_rd", o_rd, 1'b0);
    check("R10 o_rd_valid", o_rd_valid, 1'b0);
    check("R10 o_cmp", o_cmp, 1'b0);
    check("R10 o_cmp_valid", o_cmp_valid, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 o_rd_valid after release", o_rd_valid, 1'b0);
    check("R10 o_cmp after release", o_cmp, 1'b0);

    run_op(32'h12345678, 32'h0F0F0F0F, 0, 0, 0, 0, 2'd0, 2'd0, -1, "R1 add");
    run_op(32'hFFFFFFFF, 32'h00000001, 0, 0, 0, 1, 2'd0, 2'd0, -1, "R1 add ripple");
    run_op(32'hA5A50F0F, 32'h00000FFF, 1, 0, 0, 0, 2'd0, 2'd0, -1, "R2 imm add");
    run_op(32'h0000F000, 32'h00000123, 0, 0, 0, 0, 2'd0, 2'd0, -1, "R2 rs2 add");
    run_op(32'h00000005, 32'h00000007, 0, 1, 1, 0, 2'd0, 2'd0, -1, "R3 sub");
    run_op(32'hFFFFFFFF, 32'h00000001, 0, 1, 1, 0, 2'd0, 2'd0, -1, "R4 signed -1<1");
    run_op(32'h00000001, 32'hFFFFFFFF, 0, 1, 1, 0, 2'd0, 2'd0, -1, "R4 signed 1<-1");
    run_op(32'h80000000, 32'h7FFFFFFF, 0, 1, 1, 0, 2'd0, 2'd0, -1, "R4 signed min<max");
    run_op(32'hFFFFFFFF, 32'h00000001, 0, 1, 0, 0, 2'd0, 2'd0, -1, "R5 unsigned big<1");
    run_op(32'h00000001, 32'hFFFFFFFF, 0, 1, 0, 0, 2'd0, 2'd0, -1, "R5 unsigned 1<big");
    run_op(32'h80000000, 32'h7FFFFFFF, 0, 1, 0, 0, 2'd0, 2'd0, -1, "R5 unsigned min vs max");
    run_op(32'hDEADBEEF, 32'hDEADBEEF, 0, 1, 0, 0, 2'd0, 2'd0, -1, "R5 equal not less");
    run_op(32'h13572468, 32'h13572468, 0, 1, 0, 1, 2'd0, 2'd0, -1, "R6 equal");
    run_op(32'h93572468, 32'h13572468, 0, 1, 0, 1, 2'd0, 2'd0, -1, "R6 differ bit31");
    run_op(32'h13572469, 32'h13572468, 0, 1, 0, 1, 2'd0, 2'd0, -1, "R6 differ bit0");
    run_op(32'h00000000, 32'h00000000, 1, 1, 0, 1, 2'd0, 2'd0, -1, "R6 zero imm");
    run_op(32'hFFFFFFF0, 32'h00000010, 0, 1, 1, 0, 2'd0, 2'd0, -1, "R8 prime lt");
    run_op(32'hFFFFFFF0, 32'h00000010, 0, 1, 1, 0, 2'd1, 2'd0, -1, "R8 slt true");
    run_op(32'h00000010, 32'hFFFFFFF0, 0, 1, 1, 0, 2'd1, 2'd0, -1, "R8 slt stale one");
    run_op(32'h00000010, 32'hFFFFFFF0, 0, 1, 1, 0, 2'd1, 2'd0, -1, "R8 slt false");
    run_op(32'hF0F0CCAA, 32'hFF00AAAA, 0, 0, 0, 0, 2'd2, 2'd0, -1, "R9 xor");
    run_op(32'hF0F0CCAA, 32'hFF00AAAA, 0, 0, 0, 0, 2'd2, 2'd1, -1, "R9 or");
    run_op(32'hF0F0CCAA, 32'hFF00AAAA, 1, 0, 0, 0, 2'd2, 2'd2, -1, "R9 and imm");
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 0, 2'd2, 2'd3, -1, "R9 bool zero");
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 0, 2'd3, 2'd0, -1, "R9 result zero");
    run_op(32'h7FFFFFFF, 32'h00000001, 0, 0, 0, 0, 2'd0, 2'd0, 0, "R11 gap first");
    run_op(32'h0000FFFF, 32'h00000001, 0, 1, 1, 0, 2'd0, 2'd0, 17, "R11 gap mid");
    run_op(32'h80000000, 32'h00000001, 0, 1, 1, 0, 2'd0, 2'd0, 31, "R11 gap last");

    repeat (6) @(negedge clk);
    // R7: compare flag holds after the pass with no new pulse
    check("R7 cmp hold", o_cmp, last_cmp);
    check("R7 no pulse idle", o_cmp_valid, 1'b0);
    check("R11 bit queue drained", bit_q.size() == 0, 1'b1);
    check("R7 cmp queue drained", cmp_q.size() == 0, 1'b1);
    finish_run();
  end
endmodule